// File: doc/BRIEF.md
# Station Address PROM Access Decoder

This block owns the sixteen-byte station-address store of a network controller and decides, for every host access, whether it reaches that store, is handed on to the controller's register port, or is refused. Two address windows lead into it. In the port-mapped window the low sixteen offsets belong to the store and everything above them is passed on. In the memory-mapped window address bit 4 picks the side, and the low four bits give the byte index or the register offset.

Which sizes and alignments the store accepts in the port-mapped window depends on a dword-mode control input. Writes into the store also need a separate write-enable control input. Multi-byte data is assembled little-endian, and an access that is refused reads back all ones across its width. Read data is combinational. Writes land on the next rising clock edge. The store is loaded from a parameter on a synchronous, active-high reset.

Top module: `mac_prom_port`

## Requirements
- R1: While `rst` is high at a rising edge, every store byte i is loaded with byte i of the parameter `PROM_INIT`, that is bits [8i+7:8i].
- R2: A write that reaches the store changes it only when `prom_wr_en` is 1. With `prom_wr_en` at 0 the store keeps its contents. Reads are never blocked by `prom_wr_en`.
- R3: In the port-mapped window (`acc_win`=0), an address of 0x10 or above is forwarded when the size is 2 or 4. `fwd_off` is then `acc_addr[3:0]`. A size-1 access there is not forwarded and reads 0xFF.
- R4: In the port-mapped window with `dword_mode`=0, a store access is legal at size 1 at any offset, or at size 2 on an even offset. Any other size or alignment reads all ones across its width and does not write.
- R5: In the port-mapped window with `dword_mode`=1, only size 4 at an offset with bits [1:0]=00 reaches the store. Every other store access reads all ones across its width and does not write.
- R6: Multi-byte data is little-endian. The byte at the access address sits on data bits [7:0], and each following byte sits on the next higher lane. Lanes above the access width read 0.
- R7: In the memory-mapped window (`acc_win`=1) with address bit 4 clear, sizes 1, 2 and 4 reach store index `acc_addr[3:0]` at any alignment, whatever `dword_mode` is. Byte indices wrap modulo 16.
- R8: In the memory-mapped window with address bit 4 set, sizes 2 and 4 are forwarded with `fwd_off`=`acc_addr[3:0]`. Size 1 is not forwarded and reads 0xFF.
- R9: A forwarded access copies `acc_size`, `acc_wr` and `acc_wdata` onto the forward port. Its read data is `fwd_rdata` masked to the access width.
- R10: With `acc_valid` low, or a size code other than 1, 2 or 4, nothing is forwarded, the store is unchanged and `acc_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_win | input | 1 | Window select: 0 port-mapped, 1 memory-mapped |
| acc_addr | input | ADDR_W | Byte address within the window |
| acc_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| acc_wdata | input | DATA_W | Write data, little-endian lanes |
| acc_rdata | output | DATA_W | Combinational read data |
| prom_wr_en | input | 1 | Allows writes into the store |
| dword_mode | input | 1 | Port-mapped window uses 32-bit access mode |
| fwd_valid | output | 1 | Access is handed to the register port |
| fwd_size | output | 3 | Size of the forwarded access |
| fwd_off | output | IDX_W | Register offset of the forwarded access |
| fwd_wr | output | 1 | Forwarded access is a write |
| fwd_wdata | output | DATA_W | Forwarded write data |
| fwd_rdata | input | DATA_W | Read data returned by the register port |

## Verification
Two functions can act together in one cycle. A write can land in the store while the next access reads the same bytes through the other window, and a refused write can fall in the same cycle as a change of `dword_mode` or `prom_wr_en`. The bench provokes both with random window, size, alignment, mode and enable values applied every cycle, plus back-to-back write-then-read pairs across the windows. A reference byte array in the bench is updated only when the rules allow a write, and it judges every read.

// File: rtl/mac_prom_pkg.sv
package mac_prom_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_PROM = 2'd1,
    ACC_FWD  = 2'd2,
    ACC_BAD  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/mac_prom_decode.sv
module mac_prom_decode
  import mac_prom_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 4
) (
  input  logic              acc_valid,
  input  logic              acc_win,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_size,
  input  logic              dword_mode,
  output acc_kind_e         kind
);
  logic size_ok;
  logic io_low;
  logic io_prom_ok;

  assign size_ok = (acc_size == 3'd1) || (acc_size == 3'd2) || (acc_size == 3'd4);
  assign io_low  = (acc_addr[ADDR_W-1:IDX_W] == '0);

  always_comb begin
    if (dword_mode)
      io_prom_ok = (acc_size == 3'd4) && (acc_addr[1:0] == 2'b00);
    else
      io_prom_ok = (acc_size == 3'd1) || ((acc_size == 3'd2) && !acc_addr[0]);
  end

  always_comb begin
    kind = ACC_IDLE;
    if (acc_valid && size_ok) begin
      if (!acc_win) begin
        if (io_low)                kind = io_prom_ok ? ACC_PROM : ACC_BAD;
        else                       kind = (acc_size == 3'd1) ? ACC_BAD : ACC_FWD;
      end else begin
        if (!acc_addr[IDX_W])      kind = ACC_PROM;
        else                       kind = (acc_size == 3'd1) ? ACC_BAD : ACC_FWD;
      end
    end
  end
endmodule

// File: rtl/mac_prom_store.sv
module mac_prom_store #(
  parameter int                 BYTES = 16,
  parameter int                 IDX_W = 4,
  parameter int                 LANES = 4,
  parameter logic [BYTES*8-1:0] INIT  = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [IDX_W-1:0]     idx,
  input  logic [2:0]           nbytes,
  input  logic [LANES*8-1:0]   wdata,
  output logic [BYTES*8-1:0]   contents
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic [7:0] byte_q;
    logic [7:0] byte_nv;
    logic       hit;

    always_comb begin
      hit     = 1'b0;
      byte_nv = byte_q;
      for (int k = 0; k < LANES; k++) begin
        if (k < int'(nbytes) && IDX_W'(int'(idx) + k) == IDX_W'(b)) begin
          hit     = 1'b1;
          byte_nv = wdata[8*k +: 8];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst)             byte_q <= INIT[8*b +: 8];
      else if (we && hit)  byte_q <= byte_nv;
    end

    assign contents[8*b +: 8] = byte_q;
  end

  // R1: the cycle after reset the store equals its initial image
  assert_reset_image_R1: assert property (@(posedge clk)
    $past(rst) && !rst |-> contents == INIT);
endmodule

// File: rtl/mac_prom_port.sv
module mac_prom_port
  import mac_prom_pkg::*;
#(
  parameter int                    ADDR_W     = 5,
  parameter int                    DATA_W     = 32,
  parameter int                    PROM_BYTES = 16,
  parameter int                    IDX_W      = $clog2(PROM_BYTES),
  parameter logic [PROM_BYTES*8-1:0] PROM_INIT =
    128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_win,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_size,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic              prom_wr_en,
  input  logic              dword_mode,
  output logic              fwd_valid,
  output logic [2:0]        fwd_size,
  output logic [IDX_W-1:0]  fwd_off,
  output logic              fwd_wr,
  output logic [DATA_W-1:0] fwd_wdata,
  input  logic [DATA_W-1:0] fwd_rdata
);
  localparam int LANES = DATA_W / 8;

  acc_kind_e                 kind;
  logic                      store_we;
  logic [PROM_BYTES*8-1:0]   prom_flat;
  logic [7:0]                lane_byte [LANES];

  mac_prom_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
    .acc_valid  (acc_valid),
    .acc_win    (acc_win),
    .acc_addr   (acc_addr),
    .acc_size   (acc_size),
    .dword_mode (dword_mode),
    .kind       (kind)
  );

  assign store_we = (kind == ACC_PROM) && acc_wr && prom_wr_en;

  mac_prom_store #(
    .BYTES (PROM_BYTES), .IDX_W (IDX_W), .LANES (LANES), .INIT (PROM_INIT)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .we       (store_we),
    .idx      (acc_addr[IDX_W-1:0]),
    .nbytes   (acc_size),
    .wdata    (acc_wdata),
    .contents (prom_flat)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IDX_W-1:0] lane_idx;
    assign lane_idx     = IDX_W'(int'(acc_addr[IDX_W-1:0]) + k);
    assign lane_byte[k] = prom_flat[{lane_idx, 3'b000} +: 8];
  end

  always_comb begin
    acc_rdata = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(acc_size)) begin
        case (kind)
          ACC_PROM: acc_rdata[8*k +: 8] = lane_byte[k];
          ACC_BAD:  acc_rdata[8*k +: 8] = 8'hFF;
          ACC_FWD:  acc_rdata[8*k +: 8] = fwd_rdata[8*k +: 8];
          default:  acc_rdata[8*k +: 8] = 8'h00;
        endcase
      end
    end
  end

  assign fwd_valid = (kind == ACC_FWD);
  assign fwd_size  = acc_size;
  assign fwd_off   = acc_addr[IDX_W-1:0];
  assign fwd_wr    = acc_wr;
  assign fwd_wdata = acc_wdata;

  // R2: with the write enable low the store never moves
  assert_wr_locked_R2: assert property (@(posedge clk) disable iff (rst)
    !prom_wr_en |=> $stable(prom_flat));

  // R3: 16-bit port-window access above the store is forwarded
  assert_io_fwd_R3: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_win && acc_addr[ADDR_W-1:IDX_W] != '0 && acc_size == 3'd2
    |-> fwd_valid && fwd_off == acc_addr[IDX_W-1:0]
        && acc_rdata == (fwd_rdata & DATA_W'(32'h0000FFFF)));

  // R5: halfword store access in dword mode is refused
  assert_dword_refuse_R5: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_win && acc_addr[ADDR_W-1:IDX_W] == '0 && dword_mode
    && acc_size == 3'd2 |-> !fwd_valid && acc_rdata == DATA_W'(32'h0000FFFF));

  // R8: byte access to the memory-window register side is refused
  assert_mem_byte_R8: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_win && acc_addr[IDX_W] && acc_size == 3'd1
    |-> !fwd_valid && acc_rdata == DATA_W'(32'h000000FF));

  // R10: idle cycles produce no forward and zero data
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> !fwd_valid && acc_rdata == '0);
endmodule

// File: tb/test_mac_prom_port.sv
module test_mac_prom_port;
  localparam logic [127:0] INIT = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 0, acc_win = 0, acc_wr = 0;
  logic [4:0]  acc_addr = '0;
  logic [2:0]  acc_size = 3'd1;
  logic [31:0] acc_wdata = '0, acc_rdata, fwd_wdata, fwd_rdata = '0;
  logic        prom_wr_en = 0, dword_mode = 0;
  logic        fwd_valid, fwd_wr;
  logic [2:0]  fwd_size;
  logic [3:0]  fwd_off;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [16];

  always #2 clk = ~clk;

  mac_prom_port i_mac_prom_port (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_win(acc_win),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .prom_wr_en(prom_wr_en),
    .dword_mode(dword_mode), .fwd_valid(fwd_valid), .fwd_size(fwd_size),
    .fwd_off(fwd_off), .fwd_wr(fwd_wr), .fwd_wdata(fwd_wdata),
    .fwd_rdata(fwd_rdata)
  );

  // 0 idle, 1 store, 2 forward, 3 refused
  function automatic int ref_kind(bit v, bit w, logic [4:0] a, int sz, bit dw);
    if (!v || !(sz == 1 || sz == 2 || sz == 4)) return 0;
    if (w) begin
      if (a[4]) return (sz == 1) ? 3 : 2;
      return 1;
    end
    if (a >= 5'd16) return (sz == 1) ? 3 : 2;
    if (dw) return (sz == 4 && a[1:0] == 2'b00) ? 1 : 3;
    if (sz == 1 || (sz == 2 && !a[0])) return 1;
    return 3;
  endfunction

  function automatic logic [31:0] ref_rdata(int kd, logic [4:0] a, int sz, logic [31:0] fr);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < sz) begin
        if (kd == 1) r[8*k +: 8] = model[(int'(a[3:0]) + k) % 16];
        else if (kd == 3) r[8*k +: 8] = 8'hFF;
        else if (kd == 2) r[8*k +: 8] = fr[8*k +: 8];
      end
    end
    return r;
  endfunction

  function automatic string ref_tag(int kd, bit w, logic [4:0] a, bit dw);
    if (kd == 0) return "R10";
    if (w) return a[4] ? "R8" : "R7";
    if (a >= 5'd16) return "R3";
    return dw ? "R5" : "R4";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(bit v, bit w, logic [4:0] a, logic [2:0] sz, bit wr,
                        logic [31:0] wd, bit we, bit dw, string tag_over);
    int kd;
    string tg;
    @(negedge clk);
    acc_valid = v; acc_win = w; acc_addr = a; acc_size = sz; acc_wr = wr;
    acc_wdata = wd; prom_wr_en = we; dword_mode = dw; fwd_rdata = $urandom;
    #1;
    kd = ref_kind(v, w, a, int'(sz), dw);
    tg = (tag_over != "") ? tag_over : ref_tag(kd, w, a, dw);
    check(tg, acc_rdata, ref_rdata(kd, a, int'(sz), fwd_rdata));
    check(tg, 32'(fwd_valid), 32'(kd == 2));
    if (kd == 2) begin
      check("R9", {fwd_wdata[30:0] ^ acc_wdata[30:0], fwd_wr, fwd_size, fwd_off},
                  {31'd0, wr, sz, a[3:0]});
    end
    if (kd == 1 && wr && we)
      for (int k = 0; k < int'(sz); k++) model[(int'(a[3:0]) + k) % 16] = wd[8*k +: 8];
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) model[i] = INIT[8*i +: 8];
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1: reset image read byte by byte through the memory window
    for (int i = 0; i < 16; i++) access(1, 1, 5'(i), 3'd1, 0, 0, 0, 0, "R1");
    // R6: little-endian dword from the port window in dword mode
    access(1, 0, 5'd4, 3'd4, 0, 0, 0, 1, "R6");
    check("R6", acc_rdata, {INIT[63:56], INIT[55:48], INIT[47:40], INIT[39:32]});
    // R2: locked write then readback, enabled write then readback
    access(1, 0, 5'd2, 3'd2, 1, 32'h0000BEEF, 0, 0, "R2");
    access(1, 1, 5'd2, 3'd2, 0, 0, 0, 0, "R2");
    check("R2", acc_rdata, {16'h0, INIT[31:16]});
    access(1, 0, 5'd2, 3'd2, 1, 32'h0000BEEF, 1, 0, "R2");
    access(1, 1, 5'd2, 3'd2, 0, 0, 0, 1, "R2");
    check("R2", acc_rdata, 32'h0000BEEF);
    // R4/R5: refused writes leave store untouched
    access(1, 0, 5'd3, 3'd2, 1, 32'h12345678, 1, 0, "R4");
    access(1, 0, 5'd8, 3'd1, 1, 32'h000000AA, 1, 1, "R5");
    access(1, 1, 5'd8, 3'd1, 0, 0, 0, 0, "R5");
    check("R5", acc_rdata, {24'h0, INIT[71:64]});
    // R7: wrapping dword write at index 15 in the memory window
    access(1, 1, 5'd15, 3'd4, 1, 32'hA1B2C3D4, 1, 1, "R7");
    access(1, 1, 5'd15, 3'd4, 0, 0, 0, 0, "R7");
    check("R7", acc_rdata, 32'hA1B2C3D4);
    access(1, 1, 5'd0, 3'd1, 0, 0, 0, 0, "R7");
    check("R7", acc_rdata, 32'h000000C3);
    // R3, R8, R10 corners
    access(1, 0, 5'd16, 3'd1, 1, 32'h55, 1, 0, "R3");
    access(1, 1, 5'd20, 3'd1, 0, 0, 0, 0, "R8");
    access(1, 1, 5'd22, 3'd4, 1, 32'hCAFEF00D, 1, 0, "R8");
    access(1, 0, 5'd0, 3'd3, 1, 32'h77, 1, 0, "R10");
    access(0, 0, 5'd0, 3'd1, 1, 32'h77, 1, 0, "R10");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] sz;
      int pick = $urandom_range(0, 9);
      sz = (pick < 3) ? 3'd1 : (pick < 6) ? 3'd2 : (pick < 9) ? 3'd4 : 3'($urandom_range(0, 7));
      access($urandom_range(0, 9) != 0, 1'($urandom), 5'($urandom), sz,
             1'($urandom), $urandom, 1'($urandom), $urandom_range(0, 9) < 3, "");
    end
    // full readback of the store after the random phase
    for (int i = 0; i < 16; i += 2) access(1, 0, 5'(i), 3'd2, 0, 0, 0, 0, "R2");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule